// File: doc/BRIEF.md
# Hard-Sector Hole Separator and Drive Ready

This block watches the single photo-sensor pulse stream of a hard-sectored minidisk and splits it into two pulse outputs. One carries sector holes and the other carries the index hole. The index hole is the extra hole punched midway between the last sector hole and the first one. The block tells it apart by timing alone: a hole that arrives soon after a sector hole is the index. The hole after an index is always a sector hole.

The same gap counter that measures hole spacing also serves as a retriggerable speed monitor. While holes keep arriving within the speed window, the disk counts as up to speed. The window is 15 ms for 16-sector media and 25 ms for 10-sector media. Ready is raised only when all of the following hold:
- the drive is selected;
- select has been held for 50 ms;
- motor-on has been held for one second;
- the disk is up to speed.

Ready falls at once when select drops. It also falls when the hole stream stalls. All times are counters scaled by the `CYC_PER_MS` parameter.

Top module: `hole_sep_ready`

## Requirements
- R1: While rst_ni is low, index_o, sector_o and ready_o are all low.
- R2: A hole whose input rise comes more than THR clock cycles after the previous hole's rise produces a one-cycle pulse on sector_o. THR is 75/8 ms worth of cycles (3/4 of a 12.5 ms sector period) with media16_i=1. The first hole after reset is also a sector.
- R3: A hole whose rise comes at most THR cycles after the rise of a hole classified as a sector produces a one-cycle pulse on index_o and none on sector_o.
- R4: The hole directly following an index hole is always a sector, whatever its spacing. No hole ever pulses index_o and sector_o together.
- R5: ready_o stays low until motor_on_i has been high for 1000 ms of cycles without a break. Dropping motor_on_i for one sampled edge restarts that wait.
- R6: ready_o stays low until drive_select_i has been high for 50 ms of cycles without a break.
- R7: Speed is good from the cycle a hole is classified until TO cycles pass with no further hole. TO is 15 ms with media16_i=1 and 25 ms with media16_i=0. ready_o is low while speed is not good.
- R8: ready_o goes low in the same cycle drive_select_i goes low, without waiting for a clock edge.
- R9: With media16_i=0 (10-sector media), THR becomes 15 ms of cycles (3/4 of a 20 ms period) and TO becomes 25 ms.
- R10: Each hole gives exactly one output pulse, however many cycles the hole input stays high. The pulse appears after the third rising clock edge following the hole input's rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hole_i | input | 1 | Raw combined index/sector hole pulse, asynchronous |
| drive_select_i | input | 1 | Drive is selected |
| motor_on_i | input | 1 | Spindle motor is commanded on |
| media16_i | input | 1 | 1: 16-sector media, 0: 10-sector media |
| index_o | output | 1 | One-cycle pulse per index hole |
| sector_o | output | 1 | One-cycle pulse per sector hole |
| ready_o | output | 1 | Selected, spun up, and up to speed |

## Verification
A hole pulse rises on a falling clock edge. Its sector or index pulse is then sampled on the third falling edge after that, and the bench confirms both lines are quiet on the fourth. The bench also models good speed directly: good speed ends after TO+3 rising edges with no new hole, counted from the input rise. Ready is checked both at the pulse sample and on the last falling edge before the next hole. Motor and select hold times are tracked by bench counters that advance on the same rising edges as the design, so ready is compared every time it is sampled. The select-drop check samples one time unit after the input falls, with no clock edge in between.

// File: rtl/hole_sep_pkg.sv
package hole_sep_pkg;
  function automatic int cnt_w(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/hole_edge_sync.sv
module hole_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= d_i;

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) sr_q[g] <= 1'b0;
      else         sr_q[g] <= sr_q[g-1];
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];

  // R10
  edge_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hole_classifier.sv
module hole_classifier #(
  parameter int TO16  = 120,
  parameter int TO10  = 200,
  parameter int THR16 = 75,
  parameter int THR10 = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic media16_i,
  output logic index_o,
  output logic sector_o,
  output logic speed_ok_o
);
  import hole_sep_pkg::*;
  localparam int GW = cnt_w((TO10 > TO16) ? TO10 : TO16);

  logic [GW-1:0] gap_q, to_c, thr_c;
  logic [GW:0]   gap_nx;
  logic          prev_idx_q, ok_q, is_idx;

  assign to_c   = media16_i ? GW'(TO16)  : GW'(TO10);
  assign thr_c  = media16_i ? GW'(THR16) : GW'(THR10);
  assign gap_nx = {1'b0, gap_q} + 1'b1;
  // gap_q holds spacing-1 at the next rise; index only right after a sector
  assign is_idx = !prev_idx_q && (gap_q < thr_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '1;
      prev_idx_q <= 1'b0;
      ok_q       <= 1'b0;
      index_o    <= 1'b0;
      sector_o   <= 1'b0;
    end else begin
      index_o  <= rise_i & is_idx;
      sector_o <= rise_i & ~is_idx;
      if (rise_i) begin
        gap_q      <= '0;
        ok_q       <= 1'b1;
        prev_idx_q <= is_idx;
      end else begin
        if (gap_q < to_c) gap_q <= gap_nx[GW-1:0];
        if (gap_nx >= {1'b0, to_c}) ok_q <= 1'b0;
      end
    end
  end

  assign speed_ok_o = ok_q;

  // R7
  speed_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(speed_ok_o) |-> $past(rise_i));
  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (index_o || sector_o) |=> !(index_o || sector_o));
endmodule

// File: rtl/ready_ctrl.sv
module ready_ctrl #(
  parameter int MOTOR_DLY = 8000,
  parameter int SEL_DLY   = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic motor_on_i,
  input  logic drive_select_i,
  input  logic speed_ok_i,
  output logic ready_o
);
  import hole_sep_pkg::*;
  localparam int MW = cnt_w(MOTOR_DLY);
  localparam int SW = cnt_w(SEL_DLY);

  logic [MW-1:0] mot_q;
  logic [SW-1:0] sel_q;
  logic          mot_full, sel_full;

  assign mot_full = (mot_q == MW'(MOTOR_DLY));
  assign sel_full = (sel_q == SW'(SEL_DLY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mot_q <= '0;
      sel_q <= '0;
    end else begin
      if (!motor_on_i)    mot_q <= '0;
      else if (!mot_full) mot_q <= mot_q + 1'b1;
      if (!drive_select_i) sel_q <= '0;
      else if (!sel_full)  sel_q <= sel_q + 1'b1;
    end
  end

  // select gates combinationally so deselect drops ready at once
  assign ready_o = drive_select_i & sel_full & mot_full & speed_ok_i;

  // R5
  motor_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(motor_on_i));
  // R6
  select_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(drive_select_i));
endmodule

// File: rtl/hole_sep_ready.sv
module hole_sep_ready #(
  parameter int CYC_PER_MS  = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hole_i,
  input  logic drive_select_i,
  input  logic motor_on_i,
  input  logic media16_i,
  output logic index_o,
  output logic sector_o,
  output logic ready_o
);
  localparam int THR16     = CYC_PER_MS * 75 / 8;
  localparam int THR10     = CYC_PER_MS * 15;
  localparam int TO16      = CYC_PER_MS * 15;
  localparam int TO10      = CYC_PER_MS * 25;
  localparam int SEL_DLY   = CYC_PER_MS * 50;
  localparam int MOTOR_DLY = CYC_PER_MS * 1000;

  logic rise, speed_ok;

  hole_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hole_i), .rise_o(rise)
  );

  hole_classifier #(
    .TO16(TO16), .TO10(TO10), .THR16(THR16), .THR10(THR10)
  ) u_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .media16_i(media16_i),
    .index_o(index_o), .sector_o(sector_o), .speed_ok_o(speed_ok)
  );

  ready_ctrl #(.MOTOR_DLY(MOTOR_DLY), .SEL_DLY(SEL_DLY)) u_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .motor_on_i(motor_on_i),
    .drive_select_i(drive_select_i), .speed_ok_i(speed_ok), .ready_o(ready_o)
  );
endmodule

// File: tb/tb_hole_sep_ready.sv
`timescale 1ns/1ps
module tb_hole_sep_ready;
  localparam int C     = 8;
  localparam int THR16 = C * 75 / 8;
  localparam int THR10 = C * 15;
  localparam int TO16  = C * 15;
  localparam int TO10  = C * 25;
  localparam int SELD  = C * 50;
  localparam int MOTD  = C * 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hole = 1'b0, sel = 1'b0, mot = 1'b0, m16 = 1'b1;
  logic idx_o, sec_o, rdy_o;

  int checks = 0, errors = 0;
  int mcnt = 0, scnt = 0;
  bit first = 1'b1, prev_idx = 1'b0, done = 1'b0;
  int last_d = 0;

  always #4 clk = ~clk;

  hole_sep_ready #(.CYC_PER_MS(C), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hole_i(hole), .drive_select_i(sel),
    .motor_on_i(mot), .media16_i(m16), .index_o(idx_o), .sector_o(sec_o),
    .ready_o(rdy_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin mcnt <= 0; scnt <= 0; end
    else begin
      mcnt <= mot ? ((mcnt < MOTD) ? mcnt + 1 : mcnt) : 0;
      scnt <= sel ? ((scnt < SELD) ? scnt + 1 : scnt) : 0;
    end
  end

  function automatic int thr_f(input bit m); return m ? THR16 : THR10; endfunction
  function automatic int to_f(input bit m);  return m ? TO16 : TO10;   endfunction
  function automatic bit exp_ready(input bit spd);
    return sel && (mcnt >= MOTD) && (scnt >= SELD) && spd;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; d = cycles until the next hole rise
  task automatic send_hole(input int d);
    bit ei;
    string tg;
    ei = !first && !prev_idx && (last_d <= thr_f(m16));
    tg = ei ? "R3 index" : (prev_idx ? "R4 after-index" : (m16 ? "R2 sector" : "R9 sector"));
    hole = 1'b1;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      if (i == 2) hole = 1'b0;
      if (i == 3) begin
        check(idx_o == ei && sec_o == !ei, tg, {idx_o, sec_o}, {ei, !ei});
        check(!(idx_o && sec_o), "R4 exclusive", {idx_o, sec_o}, 1);
        check(rdy_o == exp_ready(1'b1), "R5 R6 ready at pulse", rdy_o, exp_ready(1'b1));
      end
      if (i == 4)
        check(!idx_o && !sec_o, "R10 single pulse", {idx_o, sec_o}, 0);
      if (i == d && d > 4)
        check(rdy_o == exp_ready(d < to_f(m16) + 3), "R7 ready before next hole",
              rdy_o, exp_ready(d < to_f(m16) + 3));
    end
    prev_idx = ei;
    first    = 1'b0;
    last_d   = d;
  endtask

  task automatic rev16();
    for (int s = 0; s < 15; s++) send_hole(100);
    send_hole(50);
    send_hole(50);
  endtask

  task automatic rev10();
    for (int s = 0; s < 9; s++) send_hole(160);
    send_hole(80);
    send_hole(80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    check(!idx_o && !sec_o && !rdy_o, "R1 reset", {idx_o, sec_o, rdy_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mot = 1'b1; sel = 1'b1; m16 = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 6; r++) rev16();   // R5: ready appears after motor wait
    check(rdy_o == 1'b1, "R5 ready after spin-up", rdy_o, 1);

    // R3 boundary: spacing exactly THR is index, THR+1 is sector
    send_hole(THR16);
    send_hole(100);
    send_hole(THR16 + 1);
    send_hole(100);
    // R4: short gap after index still sector
    send_hole(30);
    send_hole(20);
    send_hole(100);

    // R7 speed timeout window
    send_hole(TO16 + 2);
    send_hole(TO16 + 3);
    send_hole(TO16 + 20);
    send_hole(100);
    check(rdy_o == 1'b1, "R7 speed restored", rdy_o, 1);

    // R8 immediate drop on deselect
    check(rdy_o == 1'b1, "R8 ready before deselect", rdy_o, 1);
    sel = 1'b0;
    #1;
    check(rdy_o == 1'b0, "R8 ready drops without clock", rdy_o, 0);
    @(negedge clk); @(negedge clk);
    sel = 1'b1;
    send_hole(100);
    check(rdy_o == 1'b0, "R6 select delay pending", rdy_o, 0);
    for (int k = 0; k < 6; k++) send_hole(100);
    check(rdy_o == 1'b1, "R6 ready after select delay", rdy_o, 1);

    // R9 ten-sector media
    m16 = 1'b0;
    rev10();
    rev10();
    send_hole(THR10);
    send_hole(160);
    send_hole(THR10 + 1);
    send_hole(TO10 - 10);
    send_hole(TO10 + 5);
    send_hole(160);

    // random spacing and media
    for (int n = 0; n < 90; n++) begin
      m16 = $urandom_range(0, 1);
      send_hole($urandom_range(5, 240));
    end
    m16 = 1'b1;
    for (int k = 0; k < 3; k++) send_hole(100);

    // R5 motor break restarts spin-up wait
    mot = 1'b0;
    @(negedge clk); @(negedge clk);
    mot = 1'b1;
    for (int k = 0; k < 4; k++) send_hole(100);
    check(rdy_o == 1'b0, "R5 motor wait restarted", rdy_o, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule